// File: doc/BRIEF.md
# Parallel-Prefix FSM State Evaluator

This block evaluates a small three-state Mealy machine over a whole window of input symbols in one clock. It does not step one state per cycle. Each symbol becomes a next-state function: a vector of next states, one entry per present state. A log-depth Kogge-Stone network composes these functions into prefix functions. The block applies each prefix function to the initial state, which gives every intermediate state at once. It then derives the Mealy output of each step from the state before that step and the symbol.

A client presents a window of `N_SYM` one-bit symbols together with an initial state and raises `win_valid` for one cycle. One cycle later, `res_valid` is high, and the registered results hold every state the machine passes through and every output it emits. A new window may be presented on every cycle.

The machine has three states, named ST_A, ST_B and ST_C. On symbol 1:
- ST_A stays in ST_A.
- ST_B goes to ST_C.
- ST_C goes to ST_A.

On symbol 0, every state goes to ST_B. The only transition that emits a 1 is ST_C on symbol 1 (ST_C to ST_A); all others emit 0.

Top module: `fsm_scan_eval`

## Requirements
- R1: States are 2-bit codes: ST_A=0, ST_B=1, ST_C=2. Symbol k is `win_sym[k]`, and symbol 0 is applied first. `res_state[2k+1:2k]` holds the state reached after symbol k. A result never contains code 3.
- R2: The transitions are: ST_A on 0 goes to ST_B, and on 1 stays in ST_A. ST_B on 0 stays in ST_B, and on 1 goes to ST_C. ST_C on 0 goes to ST_B, and on 1 goes to ST_A.
- R3: `res_out[k]` is 1 exactly when the state before symbol k is ST_C and `win_sym[k]` is 1. For k=0, the state before the symbol is the initial state.
- R4: `res_valid` is high in the cycle after each cycle in which `win_valid` is high, and low otherwise. The results then belong to the window sampled in that earlier cycle.
- R5: An `init_state` of code 3 is treated as ST_A.
- R6: While `win_valid` is low, `res_state` and `res_out` keep their values.
- R7: Under reset, `res_valid` is 0, `res_state` is all zeros (ST_A in every field), and `res_out` is 0.
- R8: Windows presented on consecutive cycles each produce their own result, on consecutive cycles and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_valid | input | 1 | The window on `win_sym`/`init_state` is sampled this cycle |
| win_sym | input | N_SYM | Input symbols; bit 0 is applied first |
| init_state | input | 2 | State before symbol 0 |
| res_valid | output | 1 | The results are from the window of the previous cycle |
| res_state | output | 2*N_SYM | State after each symbol, 2 bits per symbol |
| res_out | output | N_SYM | Mealy output of each symbol |

## Verification
A wrong composition entry in the prefix network shows up directly in `res_state` one cycle after the window. Because each output is derived from the previous state, the same error also shows up as wrong bits in `res_out` at the following positions. Errors from combining with the wrong distance only appear at high indices, in windows whose symbol mix separates the states. For that reason, the bench compares every field against a sequential model over a varied set of windows, including back-to-back ones. The check on the first field isolates the leaf table from the network.

// File: rtl/fsm_scan_pkg.sv
package fsm_scan_pkg;
    localparam int ST_W   = 2;
    localparam int ST_NUM = 3;

    typedef enum logic [ST_W-1:0] {
        ST_A = 2'd0,
        ST_B = 2'd1,
        ST_C = 2'd2
    } fsm_st_e;

    // Next state for each present state: entry p = next state from state p
    typedef logic [ST_NUM-1:0][ST_W-1:0] st_map_t;

    // Apply a function to a state; an out-of-range state reads entry 0
    function automatic logic [ST_W-1:0] map_apply(st_map_t f, logic [ST_W-1:0] s);
        logic [ST_W-1:0] r;
        r = f[0];
        for (int i = 0; i < ST_NUM; i++) begin
            if (s == ST_W'(i)) r = f[i];
        end
        return r;
    endfunction

    // (outer o inner)[s] = outer[inner[s]]; the later symbols are on the outside
    function automatic st_map_t map_compose(st_map_t outer, st_map_t inner);
        st_map_t r;
        for (int s = 0; s < ST_NUM; s++) begin
            r[s] = map_apply(outer, inner[s]);
        end
        return r;
    endfunction
endpackage

// File: rtl/fsm_scan_leaf.sv
module fsm_scan_leaf
    import fsm_scan_pkg::*;
(
    input  logic    sym,
    output st_map_t fn
);
    always_comb begin
        for (int p = 0; p < ST_NUM; p++) begin
            unique case (fsm_st_e'(p[ST_W-1:0]))
                ST_A:    fn[p] = sym ? ST_A : ST_B;
                ST_B:    fn[p] = sym ? ST_C : ST_B;
                ST_C:    fn[p] = sym ? ST_A : ST_B;
                default: fn[p] = ST_A;
            endcase
        end
    end
endmodule

// File: rtl/fsm_scan_tree.sv
module fsm_scan_tree
    import fsm_scan_pkg::*;
#(
    parameter int N = 16
) (
    input  st_map_t [N-1:0] leaf_fn,
    output st_map_t [N-1:0] pre_fn
);
    localparam int LG = $clog2(N);

    st_map_t [N-1:0] stage [LG+1];

    assign stage[0] = leaf_fn;

    for (genvar l = 0; l < LG; l++) begin : g_lvl
        localparam int DIST = 1 << l;
        for (genvar i = 0; i < N; i++) begin : g_col
            if (i >= DIST) begin : g_comb
                assign stage[l+1][i] = map_compose(stage[l][i], stage[l][i-DIST]);
            end else begin : g_pass
                assign stage[l+1][i] = stage[l][i];
            end
        end
    end

    assign pre_fn = stage[LG];
endmodule

// File: rtl/fsm_scan_mealy.sv
module fsm_scan_mealy
    import fsm_scan_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [ST_W-1:0]   start_st,
    input  st_map_t [N-1:0]   pre_fn,
    input  logic [N-1:0]      sym,
    output logic [ST_W*N-1:0] nxt_st,
    output logic [N-1:0]      step_out
);
    for (genvar k = 0; k < N; k++) begin : g_step
        logic [ST_W-1:0] before_st;
        assign nxt_st[ST_W*k +: ST_W] = map_apply(pre_fn[k], start_st);
        if (k == 0) begin : g_first
            assign before_st = start_st;
        end else begin : g_rest
            assign before_st = nxt_st[ST_W*(k-1) +: ST_W];
        end
        assign step_out[k] = (before_st == ST_C) && sym[k];
    end
endmodule

// File: rtl/fsm_scan_eval.sv
module fsm_scan_eval
    import fsm_scan_pkg::*;
#(
    parameter int N_SYM = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  win_valid,
    input  logic [N_SYM-1:0]      win_sym,
    input  logic [ST_W-1:0]       init_state,
    output logic                  res_valid,
    output logic [ST_W*N_SYM-1:0] res_state,
    output logic [N_SYM-1:0]      res_out
);
    logic [ST_W-1:0]       start_st;
    st_map_t [N_SYM-1:0]   leaf_fn;
    st_map_t [N_SYM-1:0]   pre_fn;
    logic [ST_W*N_SYM-1:0] nxt_st;
    logic [N_SYM-1:0]      step_out;

    assign start_st = (init_state < ST_W'(ST_NUM)) ? init_state : ST_A;

    for (genvar k = 0; k < N_SYM; k++) begin : g_leaf
        fsm_scan_leaf u_leaf (
            .sym (win_sym[k]),
            .fn  (leaf_fn[k])
        );
    end

    fsm_scan_tree #(.N(N_SYM)) u_tree (
        .leaf_fn (leaf_fn),
        .pre_fn  (pre_fn)
    );

    fsm_scan_mealy #(.N(N_SYM)) u_mealy (
        .start_st (start_st),
        .pre_fn   (pre_fn),
        .sym      (win_sym),
        .nxt_st   (nxt_st),
        .step_out (step_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_valid <= 1'b0;
        else        res_valid <= win_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_state <= '0;
            res_out   <= '0;
        end else if (win_valid) begin
            res_state <= nxt_st;
            res_out   <= step_out;
        end
    end
endmodule

// File: rtl/fsm_scan_chk.sv
module fsm_scan_chk #(
    parameter int N_SYM = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 win_valid,
    input logic [N_SYM-1:0]     win_sym,
    input logic [1:0]           init_state,
    input logic                 res_valid,
    input logic [2*N_SYM-1:0]   res_state,
    input logic [N_SYM-1:0]     res_out
);
    function automatic logic [1:0] one_step(logic [1:0] s, logic x);
        case (s)
            2'd1:    return x ? 2'd2 : 2'd1;
            2'd2:    return x ? 2'd0 : 2'd1;
            default: return x ? 2'd0 : 2'd1;
        endcase
    endfunction

    function automatic logic fields_legal(logic [2*N_SYM-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int k = 0; k < N_SYM; k++) begin
            if (v[2*k +: 2] == 2'd3) ok = 1'b0;
        end
        return ok;
    endfunction

    // R4
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |=> res_valid);

    // R4
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |=> !res_valid);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |=> ($stable(res_state) && $stable(res_out)));

    // R1
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> fields_legal(res_state));

    // R2 R5
    first_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |=> (res_state[1:0] == one_step($past(init_state), $past(win_sym[0]))));

    for (genvar k = 0; k < N_SYM; k++) begin : g_out
        // R3
        out_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (res_valid && res_out[k]) |-> $past(win_sym[k]));
        if (k == 0) begin : g_first
            // R3
            out_from_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (res_valid && res_out[0]) |-> ($past(init_state) == 2'd2));
        end else begin : g_rest
            // R3
            out_from_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (res_valid && res_out[k]) |-> (res_state[2*k-2 +: 2] == 2'd2));
        end
    end
endmodule

bind fsm_scan_eval fsm_scan_chk #(.N_SYM(N_SYM)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_valid  (win_valid),
    .win_sym    (win_sym),
    .init_state (init_state),
    .res_valid  (res_valid),
    .res_state  (res_state),
    .res_out    (res_out)
);

// File: tb/fsm_scan_eval_test.sv
module fsm_scan_eval_test;
    localparam int N = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           win_valid = 1'b0;
    logic [N-1:0]   win_sym = '0;
    logic [1:0]     init_state = 2'd0;
    logic           res_valid;
    logic [2*N-1:0] res_state;
    logic [N-1:0]   res_out;

    int checks = 0;
    int errors = 0;
    int pushed = 0;
    int popped = 0;

    logic [2*N-1:0] exp_st_q[$];
    logic [N-1:0]   exp_out_q[$];
    string          tag_q[$];
    logic [2*N-1:0] last_st;
    logic [N-1:0]   last_out;
    logic           vin_d;

    always #10 clk = ~clk;

    fsm_scan_eval #(.N_SYM(N)) uut (
        .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_sym(win_sym),
        .init_state(init_state), .res_valid(res_valid), .res_state(res_state),
        .res_out(res_out)
    );

    function automatic logic [1:0] ref_step(logic [1:0] s, logic x);
        if (s == 2'd1) return x ? 2'd2 : 2'd1;
        return x ? 2'd0 : 2'd1;
    endfunction

    task automatic drive_window(input logic [N-1:0] sym, input logic [1:0] init, input string tag);
        logic [1:0]     s;
        logic [2*N-1:0] st;
        logic [N-1:0]   o;
        s = (init == 2'd3) ? 2'd0 : init;
        for (int k = 0; k < N; k++) begin
            o[k] = (s == 2'd2) && sym[k];
            s = ref_step(s, sym[k]);
            st[2*k +: 2] = s;
        end
        @(negedge clk);
        win_valid  = 1'b1;
        win_sym    = sym;
        init_state = init;
        exp_st_q.push_back(st);
        exp_out_q.push_back(o);
        tag_q.push_back(tag);
        last_st  = st;
        last_out = o;
        pushed++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            win_valid = 1'b0;
            win_sym   = ~win_sym;
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) vin_d <= 1'b0;
        else        vin_d <= win_valid;
    end

    // Monitor: R4 timing plus scoreboard pops
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (res_valid !== vin_d) begin
                errors++;
                $display("FAIL R4 res_valid: got %0b expected %0b", res_valid, vin_d);
            end
            if (res_valid) begin
                if (exp_st_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R4 unexpected result: got 1 expected 0");
                end else begin
                    logic [2*N-1:0] est;
                    logic [N-1:0]   eo;
                    string          tg;
                    est = exp_st_q.pop_front();
                    eo  = exp_out_q.pop_front();
                    tg  = tag_q.pop_front();
                    popped++;
                    checks += 2;
                    if (res_state !== est) begin
                        errors++;
                        $display("FAIL R1 R2 states [%s]: got %h expected %h", tg, res_state, est);
                    end
                    if (res_out !== eo) begin
                        errors++;
                        $display("FAIL R3 outputs [%s]: got %h expected %h", tg, res_out, eo);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7 reset values
        checks++;
        if (res_valid !== 1'b0 || res_state !== '0 || res_out !== '0) begin
            errors++;
            $display("FAIL R7 reset: got %b %h %h expected 0 0 0", res_valid, res_state, res_out);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // Nine-symbol example 0 0 1 1 1 0 1 0 1 from ST_A, zero padded
        drive_window(16'h015C, 2'd0, "R2 example");
        idle(2);
        drive_window('1, 2'd2, "R3 all ones from C");
        drive_window('0, 2'd2, "R3 all zeros from C");
        idle(1);
        drive_window(16'h5555, 2'd1, "R3 alternating from B");
        idle(1);
        // R5 code 3 treated as ST_A
        drive_window(16'hB6D9, 2'd3, "R5 init code 3");
        drive_window(16'h0001, 2'd3, "R5 init code 3 single one");
        idle(1);

        // R8 back-to-back windows
        for (int i = 0; i < 8; i++) begin
            drive_window(N'($urandom), 2'($urandom_range(0, 2)), "R8 back-to-back");
        end
        idle(1);

        // R6 hold while win_valid is low (inputs toggle in idle)
        idle(4);
        checks++;
        if (res_state !== last_st || res_out !== last_out) begin
            errors++;
            $display("FAIL R6 hold: got %h/%h expected %h/%h", res_state, res_out, last_st, last_out);
        end

        for (int i = 0; i < 40; i++) begin
            drive_window(N'($urandom), 2'($urandom_range(0, 3)), "R1 random");
            if (i % 3 == 0) idle(1);
        end
        idle(3);

        // R8 every window gave exactly one result
        checks++;
        if (popped != pushed) begin
            errors++;
            $display("FAIL R8 result count: got %0d expected %0d", popped, pushed);
        end
        finish_run();
    end
endmodule